// File: doc/BRIEF.md
# Single-Button Keyboard Report Sequencer

This block turns one pushbutton into keyboard reports for a USB interface device that sits behind a register-write port. Each time the device signals that its IN endpoint buffer is free, the sequencer may load a three-byte report into the endpoint FIFO register and then arm the endpoint by writing the byte count. A press produces a key-down report. The next buffer-free event produces a key-up report. After that, the sequencer waits until it sees the button released before it will send another press.

The button level is never sampled directly. A periodic poll timer schedules one read of the device's general-purpose input register, and bit 0 of the returned byte becomes the button level the sequencer works from. Register traffic therefore stays low. A change on the button between polls is not seen until the next read.

All register traffic goes over one request/acknowledge channel, one transaction at a time. A buffer-free event that arrives while a report is still being written is held and served as soon as the write sequence ends.

Top module: `keyrep_sequencer`

## Requirements
- R1: After reset no request is raised, the sequencer is in its idle state and the button is taken as released.
- R2: In idle with the sampled button pressed, a buffer-free event causes exactly four writes, in order: 0x08, 0x00, 0x07 to the FIFO address, then 0x03 to the byte-count address. The sequencer then moves to the key-up state.
- R3: In idle with the sampled button released, a buffer-free event is consumed and produces no write, so the endpoint stays unarmed.
- R4: In the key-up state, the next buffer-free event causes three writes of 0x00 to the FIFO address, then 0x03 to the byte-count address. The sequencer then moves to the waiting state.
- R5: In the waiting state, buffer-free events produce no writes while the sampled button stays pressed.
- R6: The button is sampled only by reading the input-register address when the poll timer expires, about once every POLL_CYCLES cycles, with none before the first expiry. Bit 0 of the read data is the level (1 = pressed). A button change between polls has no effect until the next read.
- R7: A request holds its address, data and direction stable until it is acknowledged. Only one transaction is outstanding at a time, and the request is low for at least one cycle after each acknowledge.
- R8: A buffer-free event that arrives during a write sequence is latched and served when the sequence completes. Several such events merge into one.
- R9: The waiting state returns to idle on any button sample that reads released, with no buffer-free event needed. A later press can then be reported again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| buf_avail_i | input | 1 | One-cycle pulse: IN endpoint buffer is free |
| req_o | output | 1 | Register transaction request |
| we_o | output | 1 | Direction of the request (1 = write, 0 = read) |
| addr_o | output | ADDR_W | Register address of the request |
| data_o | output | DATA_W | Write data |
| ack_i | input | 1 | Acknowledge; completes the request in the cycle it is high |
| rdata_i | input | DATA_W | Read data, valid with ack_i on a read |

## Verification
A write counts as done at the clock edge where ack_i meets req_o. A read result becomes the sampled button level at that same edge, so it affects the next event served one cycle later. A new request cannot appear until the cycle after an acknowledge. A four-write report therefore takes at least eight cycles plus the responder's random acknowledge delay. The bench does not guess cycle numbers. It waits for its own counts of acknowledged reads and writes to move, adds two clock cycles of margin, and only then compares. Checks that expect no activity look over a window longer than a full report but shorter than the poll period.

// File: rtl/keyrep_pkg.sv
package keyrep_pkg;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_RELEASE = 2'd1,
      ST_WAIT    = 2'd2
   } key_state_e;

   typedef enum logic {
      RPT_PRESS   = 1'b0,
      RPT_RELEASE = 1'b1
   } rpt_kind_e;

   // payload bytes per report; also the value written to the byte counter
   localparam int unsigned RPT_BYTES = 3;
   localparam int unsigned STEP_W    = $clog2(RPT_BYTES + 1);

   // payload byte idx of a report of the given kind
   function automatic logic [7:0] rpt_byte(rpt_kind_e kind, logic [STEP_W-1:0] idx);
      if (kind == RPT_RELEASE) return 8'h00;
      case (idx)
         STEP_W'(0): return 8'h08;   // modifier: left GUI key
         STEP_W'(2): return 8'h07;   // usage code of letter d
         default:    return 8'h00;   // reserved byte
      endcase
   endfunction

endpackage

// File: rtl/keyrep_poll_timer.sv
module keyrep_poll_timer #(
   parameter int unsigned PERIOD = 1000
) (
   input  logic clk_i,
   input  logic rst_ni,
   output logic tick_o
);
   if (PERIOD < 1) begin : g_bad_period
      $error("keyrep_poll_timer: PERIOD must be at least 1");
   end

   if (PERIOD == 1) begin : g_every
      assign tick_o = 1'b1;
   end else begin : g_count
      localparam int unsigned CNT_W = $clog2(PERIOD);
      logic [CNT_W-1:0] cnt_q;

      assign tick_o = (cnt_q == '0);

      always_ff @(posedge clk_i) begin
         if (!rst_ni)     cnt_q <= CNT_W'(PERIOD - 1);
         else if (tick_o) cnt_q <= CNT_W'(PERIOD - 1);
         else             cnt_q <= cnt_q - 1'b1;
      end

      AST_TICK_SPACED: assert property (@(posedge clk_i) disable iff (!rst_ni)
         tick_o |=> !tick_o);   // R6
   end
endmodule

// File: rtl/keyrep_bus_port.sv
module keyrep_bus_port #(
   parameter int unsigned ADDR_W = 5,
   parameter int unsigned DATA_W = 8
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              launch_i,
   input  logic              launch_we_i,
   input  logic [ADDR_W-1:0] launch_addr_i,
   input  logic [DATA_W-1:0] launch_data_i,
   output logic              busy_o,
   output logic              done_o,
   output logic              done_we_o,
   output logic              req_o,
   output logic              we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   input  logic              ack_i
);
   logic              req_q, we_q;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] data_q;

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         req_q  <= 1'b0;
         we_q   <= 1'b0;
         addr_q <= '0;
         data_q <= '0;
      end else if (req_q && ack_i) begin
         req_q <= 1'b0;
      end else if (launch_i && !req_q) begin
         req_q  <= 1'b1;
         we_q   <= launch_we_i;
         addr_q <= launch_addr_i;
         data_q <= launch_data_i;
      end
   end

   assign busy_o    = req_q;
   assign done_o    = req_q & ack_i;
   assign done_we_o = we_q;
   assign req_o     = req_q;
   assign we_o      = we_q;
   assign addr_o    = addr_q;
   assign data_o    = data_q;

   AST_REQ_STABLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && !ack_i) |=> (req_o && $stable(addr_o) && $stable(data_o) && $stable(we_o)));   // R7
   AST_REQ_GAP: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (req_o && ack_i) |=> !req_o);   // R7
   AST_LAUNCH_WHEN_FREE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      launch_i |-> !req_o);   // R7
endmodule

// File: rtl/keyrep_ctrl.sv
module keyrep_ctrl
   import keyrep_pkg::*;
#(
   parameter int unsigned ADDR_W    = 5,
   parameter int unsigned DATA_W    = 8,
   parameter int unsigned FIFO_ADDR = 3,
   parameter int unsigned BC_ADDR   = 7,
   parameter int unsigned GPIN_ADDR = 20
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              tick_i,
   input  logic              buf_avail_i,
   input  logic              busy_i,
   input  logic              done_i,
   input  logic              done_we_i,
   input  logic              rbit_i,
   output logic              launch_o,
   output logic              launch_we_o,
   output logic [ADDR_W-1:0] launch_addr_o,
   output logic [DATA_W-1:0] launch_data_o
);
   localparam logic [STEP_W-1:0] LAST_STEP = STEP_W'(RPT_BYTES);

   key_state_e        st_q, st_nxt;
   rpt_kind_e         kind_q;
   logic [STEP_W-1:0] step_q;
   logic              btn_q, ev_pend_q, poll_pend_q, seq_act_q;
   logic              serve, start_seq, issue_wr, issue_rd;
   logic              wr_done, rd_done, wr_last;

   assign wr_done   = done_i & done_we_i;
   assign rd_done   = done_i & ~done_we_i;
   assign wr_last   = (step_q == LAST_STEP);
   // a pending event is decided only with the channel quiet and no report in flight
   assign serve     = ev_pend_q & ~seq_act_q & ~busy_i;
   assign start_seq = serve & (((st_q == ST_IDLE) & btn_q) | (st_q == ST_RELEASE));
   assign issue_wr  = seq_act_q & ~busy_i;
   assign issue_rd  = poll_pend_q & ~seq_act_q & ~busy_i & ~serve;

   always_comb begin
      launch_o      = issue_wr | issue_rd;
      launch_we_o   = issue_wr;
      launch_addr_o = ADDR_W'(GPIN_ADDR);
      launch_data_o = '0;
      if (issue_wr) begin
         if (wr_last) begin
            launch_addr_o = ADDR_W'(BC_ADDR);
            launch_data_o = DATA_W'(RPT_BYTES);
         end else begin
            launch_addr_o = ADDR_W'(FIFO_ADDR);
            launch_data_o = DATA_W'(rpt_byte(kind_q, step_q));
         end
      end
   end

   always_comb begin
      st_nxt = st_q;
      case (st_q)
         ST_IDLE:    if (wr_done && wr_last)  st_nxt = ST_RELEASE;
         ST_RELEASE: if (wr_done && wr_last)  st_nxt = ST_WAIT;
         ST_WAIT:    if (rd_done && !rbit_i)  st_nxt = ST_IDLE;
         default:                             st_nxt = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk_i) begin
      if (!rst_ni) begin
         st_q        <= ST_IDLE;
         kind_q      <= RPT_PRESS;
         step_q      <= '0;
         btn_q       <= 1'b0;
         ev_pend_q   <= 1'b0;
         poll_pend_q <= 1'b0;
         seq_act_q   <= 1'b0;
      end else begin
         st_q        <= st_nxt;
         ev_pend_q   <= buf_avail_i | (ev_pend_q & ~serve);
         poll_pend_q <= tick_i | (poll_pend_q & ~issue_rd);
         if (rd_done) btn_q <= rbit_i;
         if (start_seq) begin
            seq_act_q <= 1'b1;
            step_q    <= '0;
            kind_q    <= (st_q == ST_IDLE) ? RPT_PRESS : RPT_RELEASE;
         end else if (wr_done) begin
            if (wr_last) seq_act_q <= 1'b0;
            else         step_q    <= step_q + 1'b1;
         end
      end
   end

   AST_IDLE_NO_REPORT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_IDLE && !btn_q && !seq_act_q) |=> !seq_act_q);   // R3
   AST_STEP_ORDER: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (seq_act_q && wr_done && !wr_last) |=> (step_q == $past(step_q) + 1'b1));   // R2
   AST_WAIT_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_WAIT && !(rd_done && !rbit_i)) |=> (st_q == ST_WAIT));   // R5
   AST_WAIT_EXIT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (st_q == ST_WAIT && rd_done && !rbit_i) |=> (st_q == ST_IDLE));   // R9
   AST_EVENT_KEPT: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ev_pend_q && seq_act_q) |=> ev_pend_q);   // R8
endmodule

// File: rtl/keyrep_sequencer.sv
module keyrep_sequencer #(
   parameter int unsigned ADDR_W      = 5,
   parameter int unsigned DATA_W      = 8,
   parameter int unsigned FIFO_ADDR   = 3,
   parameter int unsigned BC_ADDR     = 7,
   parameter int unsigned GPIN_ADDR   = 20,
   parameter int unsigned POLL_CYCLES = 1000
) (
   input  logic              clk_i,
   input  logic              rst_ni,
   input  logic              buf_avail_i,
   output logic              req_o,
   output logic              we_o,
   output logic [ADDR_W-1:0] addr_o,
   output logic [DATA_W-1:0] data_o,
   input  logic              ack_i,
   input  logic [DATA_W-1:0] rdata_i
);
   localparam longint unsigned ADDR_SPAN = 64'd1 << ADDR_W;

   if (ADDR_W < 1 || ADDR_W > 16) begin : g_bad_aw
      $error("keyrep_sequencer: ADDR_W out of range");
   end
   if (DATA_W < 8) begin : g_bad_dw
      $error("keyrep_sequencer: DATA_W must hold one report byte");
   end
   if (FIFO_ADDR >= ADDR_SPAN || BC_ADDR >= ADDR_SPAN || GPIN_ADDR >= ADDR_SPAN) begin : g_bad_addr
      $error("keyrep_sequencer: register address does not fit ADDR_W");
   end
   if (FIFO_ADDR == BC_ADDR || FIFO_ADDR == GPIN_ADDR || BC_ADDR == GPIN_ADDR) begin : g_dup_addr
      $error("keyrep_sequencer: register addresses must differ");
   end

   logic              tick, busy, done, done_we, launch, launch_we;
   logic [ADDR_W-1:0] launch_addr;
   logic [DATA_W-1:0] launch_data;
   logic              unused_rdata;

   assign unused_rdata = ^rdata_i[DATA_W-1:1];

   keyrep_poll_timer #(.PERIOD(POLL_CYCLES)) u_timer (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .tick_o (tick)
   );

   keyrep_ctrl #(
      .ADDR_W    (ADDR_W),
      .DATA_W    (DATA_W),
      .FIFO_ADDR (FIFO_ADDR),
      .BC_ADDR   (BC_ADDR),
      .GPIN_ADDR (GPIN_ADDR)
   ) u_ctrl (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .tick_i        (tick),
      .buf_avail_i   (buf_avail_i),
      .busy_i        (busy),
      .done_i        (done),
      .done_we_i     (done_we),
      .rbit_i        (rdata_i[0]),
      .launch_o      (launch),
      .launch_we_o   (launch_we),
      .launch_addr_o (launch_addr),
      .launch_data_o (launch_data)
   );

   keyrep_bus_port #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_port (
      .clk_i         (clk_i),
      .rst_ni        (rst_ni),
      .launch_i      (launch),
      .launch_we_i   (launch_we),
      .launch_addr_i (launch_addr),
      .launch_data_i (launch_data),
      .busy_o        (busy),
      .done_o        (done),
      .done_we_o     (done_we),
      .req_o         (req_o),
      .we_o          (we_o),
      .addr_o        (addr_o),
      .data_o        (data_o),
      .ack_i         (ack_i)
   );

   AST_RESET_QUIET: assert property (@(posedge clk_i)
      !rst_ni |=> !req_o);   // R1
endmodule

// File: tb/keyrep_sequencer_bench.sv
module keyrep_sequencer_bench;
   localparam int AW = 5, DW = 8;
   localparam int A_FIFO = 3, A_BC = 7, A_GPIN = 20, POLL = 50;
   localparam int LOGN = 1024;

   logic          clk = 1'b0, rst_n = 1'b0, ev = 1'b0;
   logic          req, we, ack = 1'b0;
   logic [AW-1:0] addr;
   logic [DW-1:0] wdata, rdata = '0;

   int checks = 0, errors = 0, cyc = 0;
   int wr_n = 0, rd_n = 0, viol = 0, dly = 0;
   logic          btn_lvl = 1'b0;
   logic [AW-1:0] log_a [LOGN];
   logic [DW-1:0] log_d [LOGN];
   logic          m_req = 1'b0;
   logic [AW-1:0] m_addr = '0;
   logic [DW-1:0] m_data = '0;

   keyrep_sequencer #(.ADDR_W(AW), .DATA_W(DW), .FIFO_ADDR(A_FIFO), .BC_ADDR(A_BC),
                      .GPIN_ADDR(A_GPIN), .POLL_CYCLES(POLL)) u_keyrep_sequencer (
      .clk_i(clk), .rst_ni(rst_n), .buf_avail_i(ev), .req_o(req), .we_o(we),
      .addr_o(addr), .data_o(wdata), .ack_i(ack), .rdata_i(rdata));

   always #4 clk = ~clk;   // 125 MHz

   // expected report word i (0..3) of a press (0) or release (1) report
   function automatic int exp_addr(int i);
      return (i == 3) ? A_BC : A_FIFO;
   endfunction
   function automatic int exp_data(int kind, int i);
      if (i == 3) return 3;
      if (kind == 1) return 0;
      return (i == 0) ? 8'h08 : ((i == 2) ? 8'h07 : 8'h00);
   endfunction

   // register-side responder and handshake monitor
   always @(negedge clk) begin
      if (m_req && !ack && (!req || addr != m_addr || wdata != m_data)) viol++;
      if (m_req && ack && req) viol++;
      m_req <= req; m_addr <= addr; m_data <= wdata;
      ack <= 1'b0;
      if (req && !ack) begin
         if (dly == 0) begin
            ack <= 1'b1;
            dly <= int'($urandom % 4);
            if (we) begin
               if (wr_n < LOGN) begin log_a[wr_n] = addr; log_d[wr_n] = wdata; end
               wr_n++;
            end else begin
               if (addr != A_GPIN) viol++;
               rdata <= {7'($urandom), btn_lvl};
               rd_n++;
            end
         end else dly <= dly - 1;
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000) begin
         checks++; errors++;
         $display("FAIL watchdog: cycle %0d reached, expected end before 150000", cyc);
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   task automatic chk(string req_tag, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s: actual %0d expected %0d", req_tag, act, exp);
      end
   endtask

   task automatic cycles(int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic pulse_ev();
      ev = 1'b1; @(negedge clk); ev = 1'b0;
   endtask

   task automatic wait_poll();
      int r0 = rd_n;
      for (int i = 0; i < 4 * POLL && rd_n == r0; i++) @(negedge clk);
      cycles(2);
   endtask

   task automatic wait_writes(int target);
      for (int i = 0; i < 400 && wr_n < target; i++) @(negedge clk);
      cycles(2);
   endtask

   task automatic chk_report(string req_tag, int base, int kind);
      for (int i = 0; i < 4; i++) begin
         chk({req_tag, " addr"}, int'(log_a[base + i]), exp_addr(i));
         chk({req_tag, " data"}, int'(log_d[base + i]), exp_data(kind, i));
      end
   endtask

   initial begin
      int base, n0, r0, bad, kind;
      void'($urandom(32'd20240611));
      cycles(4);
      rst_n = 1'b1;
      cycles(1);
      chk("R1 no request after reset", int'(req), 0);
      cycles(20);
      chk("R6 no read before first poll expiry", rd_n, 0);

      // R3: released button in idle -> event dropped
      wait_poll();
      pulse_ev(); cycles(40);
      chk("R3 idle released event writes", wr_n, 0);

      // R2: press report
      btn_lvl = 1'b1; wait_poll();
      pulse_ev(); wait_writes(4);
      chk("R2 press write count", wr_n, 4);
      chk_report("R2 press report", 0, 0);

      // R4: key-up report
      pulse_ev(); wait_writes(8);
      chk("R4 release write count", wr_n, 8);
      chk_report("R4 release report", 4, 1);

      // R5: held in waiting state
      pulse_ev(); cycles(3 * POLL);
      pulse_ev(); cycles(40);
      chk("R5 waiting held writes", wr_n, 8);

      // R9 + R6: release seen by poll alone, then stale press ignored until next poll
      btn_lvl = 1'b0; wait_poll();
      btn_lvl = 1'b1; pulse_ev(); cycles(10);
      chk("R6 change between polls ignored", wr_n, 8);
      wait_poll();
      pulse_ev(); wait_writes(12);
      chk("R9 press after release without event", wr_n, 12);
      chk_report("R9 re-armed press", 8, 0);

      // back to idle with the button pressed
      pulse_ev(); wait_writes(16);
      btn_lvl = 1'b0; wait_poll();
      btn_lvl = 1'b1; wait_poll();

      // R8: second and third events during a report are latched and merged
      n0 = wr_n;
      pulse_ev(); cycles(2); pulse_ev(); pulse_ev();
      wait_writes(n0 + 8); cycles(60);
      chk("R8 latched event write count", wr_n - n0, 8);
      chk_report("R8 press part", n0, 0);
      chk_report("R8 release part", n0 + 4, 1);

      // R6: poll rate in a quiet window
      btn_lvl = 1'b0; wait_poll();
      r0 = rd_n; cycles(20 * POLL);
      checks++;
      if (rd_n - r0 < 19 || rd_n - r0 > 21) begin
         errors++;
         $display("FAIL R6 poll rate: actual %0d expected 19..21", rd_n - r0);
      end

      // random phase: reports must alternate press / release from idle
      base = wr_n;
      for (int it = 0; it < 40; it++) begin
         btn_lvl = 1'($urandom % 2);
         for (int c = 0; c < 20 + int'($urandom % 120); c++) begin
            if ($urandom % 15 == 0) pulse_ev(); else cycles(1);
         end
      end
      btn_lvl = 1'b0; cycles(6 * POLL);
      chk("R2 random phase whole reports", (wr_n - base) % 4, 0);
      bad = 0; kind = 0;
      for (int g = base; g + 3 < wr_n && g + 3 < LOGN; g += 4) begin
         for (int i = 0; i < 4; i++)
            if (int'(log_a[g + i]) != exp_addr(i) || int'(log_d[g + i]) != exp_data(kind, i)) bad++;
         kind = 1 - kind;
      end
      chk("R4 random phase alternating reports mismatches", bad, 0);

      chk("R7 handshake violations", viol, 0);
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule